// File: doc/BRIEF.md
# Dual-Mode I2C Control/Status Slave

This block is the control and status interface of a video identification core. A host on an I2C bus writes two control bytes that configure the decoders and reads back one status byte that gathers their results. The slave answers a fixed 7-bit address. SCL and SDA are sampled by the system clock, synchronised and glitch-filtered, so the block works at both 100 kbit/s and 400 kbit/s. The SDA output is a single open-drain enable: when `sda_oe_o` is high the pad pulls the line low.

A mode strap selects how the block is run. With the strap high the block acts as a bus slave. With the strap low the bus is ignored and the two control bytes take fixed values. In that mode two fields follow the static SDA and SCL pin levels, so a board without a host can still select the amplitude check and the decoder level. The bus-written registers keep their contents while strap mode is active.

Control byte 0 fields, bit 7 down to bit 0: [7] amplitude-check disable, [6] EDTV decoder reset, [5:4] level select A, [3:2] level select B, [1] line-window select, [0] ID-1 reset. Control byte 1 fields: [7] auto-wide reset, [6] instant switch, [5:2] test (write 0), [1] area, [0] PAL (0 = 525/60, 1 = 625/50). Status byte: [7] EDTV bit 3, [6] EDTV bit 5, [5] EDTV valid, [4] ID-1 full mode, [3] ID-1 letter-box, [2] ID-1 valid, [1:0] auto-wide code.

Top module: `ctlstat_i2c_slave`

## Requirements
- R1: The slave answers only the 7-bit address 0x1C (address byte 0x38 for a write, 0x39 for a read). It acknowledges by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and the slave stays inactive until the next START.
- R2: In a write, the first data byte goes to `ctl0_o` and the second to `ctl1_o`. Both bytes are acknowledged, and each takes effect at the end of its eighth bit.
- R3: A third or later data byte in a write is not acknowledged and changes no register.
- R4: A read returns the status byte MSB first. The status is captured from `stat_i` when the address is acknowledged. A change of `stat_i` after that point does not alter the byte being sent, and SDA is only changed while SCL is low.
- R5: After the master ends the read byte with a NACK, the slave releases SDA. It answers the next transaction normally.
- R6: After reset in bus mode, `ctl0_o` = 0x14, `ctl1_o` = 0x00 and `sda_oe_o` = 0.
- R7: With `mode_i` low, `ctl0_o` = {SDA level, 0, 01, SCL ? 10 : 01, 0, 0} and `ctl1_o` = 0x00. SDA is never driven, and no bus traffic is acknowledged or written.
- R8: Register values written in bus mode reappear on the outputs when `mode_i` returns high after a strap-mode interval.
- R9: A pulse on SCL or SDA lasting fewer than 3 system clocks is ignored. It produces no START, no STOP and no clock edge.
- R10: A repeated START restarts the address phase. A STOP in the middle of a byte abandons that byte without writing it.
- R11: The block operates correctly when each SCL high and low phase lasts at least 10 system clocks. This covers both the 100 kbit/s and 400 kbit/s rates at ordinary system clock rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oversamples the bus) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Mode strap: 1 = bus slave, 0 = strap operation |
| scl_i | input | 1 | SCL pin level (in strap mode, selects level B) |
| sda_i | input | 1 | SDA pin level (in strap mode, amplitude-check disable) |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| stat_i | input | 8 | Status byte from the decoders |
| ctl0_o | output | 8 | Control byte 0 |
| ctl1_o | output | 8 | Control byte 1 |

## Verification
A protocol state that is out of step with the bus shows up at the ports as a missing or misplaced acknowledge, within the ninth clock of the byte concerned. It can also appear as a status bit shifted by one position on the next read. A byte counter or write-index error lands in the wrong control register, and this can be seen on `ctl0_o`/`ctl1_o` as soon as the STOP follows. A filter that lets a short pulse through inserts a false START or clock edge, which costs the acknowledge of the byte in progress. A wrong strap mux shows on the control outputs within a few clocks of a strap or pin change.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned CTL_BYTES = 2;
  localparam int unsigned IDX_W     = (CTL_BYTES > 1) ? $clog2(CTL_BYTES) : 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK
  } link_st_e;

  // power-up contents of the bus-written control bytes
  function automatic logic [BYTE_W-1:0] ctl_default(input int unsigned idx);
    if (idx == 0) return 8'h14;
    return 8'h00;
  endfunction

endpackage

// File: rtl/i2cs_pin_filter.sv
module i2cs_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3,
  parameter logic        RST_VAL     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o
);

  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   lvl_q, lvl_d;
  logic                   smp;

  assign smp = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= {SYNC_STAGES{RST_VAL}};
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  // the level moves only after FILT_LEN consecutive differing samples
  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (smp == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(FILT_LEN - 1)) begin
      lvl_d = smp;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= RST_VAL;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(smp) == lvl_q && $past(smp, 2) == lvl_q)); // R9

endmodule

// File: rtl/i2cs_link.sv
module i2cs_link
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic [BYTE_W-1:0] stat_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o
);

  link_st_e          state_q, state_d;
  logic              scl_q, sda_q;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] snap_q, snap_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              rw_q, rw_d;
  logic              oe_q, oe_d;
  logic              wen_q, wen_d;
  logic [IDX_W-1:0]  widx_q, widx_d;
  logic [BYTE_W-1:0] wdat_q, wdat_d;

  logic start_c, stop_c, rise_c, fall_c;

  assign start_c = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c  = scl_f & scl_q & ~sda_q & sda_f;
  assign rise_c  = scl_f & ~scl_q;
  assign fall_c  = ~scl_f & scl_q;

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    snap_d  = snap_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    rw_d    = rw_q;
    oe_d    = oe_q;
    wen_d   = 1'b0;
    widx_d  = widx_q;
    wdat_d  = wdat_q;
    if (!bus_en) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_c) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_c) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR, ST_WBYTE: begin
          if (rise_c) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_f};
            cnt_d = cnt_q + 4'd1;
          end else if (fall_c && cnt_q == 4'd8) begin
            cnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                state_d = ST_AACK;
                oe_d    = 1'b1;
                rw_d    = sh_q[0];
                idx_d   = '0;
                if (sh_q[0]) snap_d = stat_i;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              state_d = ST_WACK;
              oe_d    = 1'b1;
              wen_d   = 1'b1;
              widx_d  = idx_q;
              wdat_d  = sh_q;
            end
          end
        end
        ST_AACK: begin
          if (fall_c) begin
            cnt_d = '0;
            if (rw_q) begin
              state_d = ST_RBYTE;
              sh_d    = snap_q;
              oe_d    = ~snap_q[BYTE_W-1];
            end else begin
              state_d = ST_WBYTE;
              oe_d    = 1'b0;
            end
          end
        end
        ST_WACK: begin
          if (fall_c) begin
            oe_d = 1'b0;
            if (idx_q == IDX_W'(CTL_BYTES - 1)) begin
              state_d = ST_IDLE;
            end else begin
              idx_d   = idx_q + IDX_W'(1);
              state_d = ST_WBYTE;
              cnt_d   = '0;
            end
          end
        end
        ST_RBYTE: begin
          if (rise_c) begin
            cnt_d = cnt_q + 4'd1;
          end else if (fall_c) begin
            if (cnt_q == 4'd8) begin
              state_d = ST_RACK;
              oe_d    = 1'b0;
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (fall_c) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      sh_q    <= '0;
      snap_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      wen_q   <= 1'b0;
      widx_q  <= '0;
      wdat_q  <= '0;
    end else begin
      state_q <= state_d;
      scl_q   <= scl_f;
      sda_q   <= sda_f;
      sh_q    <= sh_d;
      snap_q  <= snap_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      rw_q    <= rw_d;
      oe_q    <= oe_d;
      wen_q   <= wen_d;
      widx_q  <= widx_d;
      wdat_q  <= wdat_d;
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wen_q;
  assign wr_idx_o  = widx_q;
  assign wr_data_o = wdat_q;

  AST_DRIVE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_f); // R1

  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && $past(bus_en) && scl_f && $past(scl_f)) |-> $stable(sda_oe_o)); // R4

  AST_STRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> !sda_oe_o); // R7

endmodule

// File: rtl/i2cs_ctl_regs.sv
module i2cs_ctl_regs
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] ctl0_o,
  output logic [BYTE_W-1:0] ctl1_o
);

  logic [CTL_BYTES-1:0][BYTE_W-1:0] regs_q, regs_d;
  logic [BYTE_W-1:0]                strap0;

  for (genvar g = 0; g < CTL_BYTES; g++) begin : g_byte
    always_comb begin
      regs_d[g] = regs_q[g];
      if (wr_en_i && wr_idx_i == IDX_W'(g)) regs_d[g] = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= ctl_default(g);
      else        regs_q[g] <= regs_d[g];
    end
  end

  // strap values: SDA -> amplitude-check disable, SCL -> level select B
  assign strap0 = {sda_f, 1'b0, 2'b01, (scl_f ? 2'b10 : 2'b01), 1'b0, 1'b0};

  assign ctl0_o = bus_en ? regs_q[0] : strap0;
  assign ctl1_o = bus_en ? regs_q[1] : '0;

  AST_NO_WRITE_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |-> !wr_en_i); // R7

endmodule

// File: rtl/ctlstat_i2c_slave.sv
module ctlstat_i2c_slave
  import i2cs_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h1C,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [7:0] stat_i,
  output logic [7:0] ctl0_o,
  output logic [7:0] ctl1_o
);

  localparam int unsigned N_PINS = 3;

  logic [N_PINS-1:0] pin_raw, pin_lvl;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;

  assign pin_raw = {mode_i, sda_i, scl_i};

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    i2cs_pin_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_LEN    (FILT_LEN),
      .RST_VAL     (1'b1)
    ) i_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (pin_raw[p]),
      .lvl_o (pin_lvl[p])
    );
  end

  i2cs_link #(
    .DEV_ADDR (DEV_ADDR)
  ) i_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (pin_lvl[2]),
    .scl_f     (pin_lvl[0]),
    .sda_f     (pin_lvl[1]),
    .stat_i    (stat_i),
    .sda_oe_o  (sda_oe_o),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx),
    .wr_data_o (wr_data)
  );

  i2cs_ctl_regs i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (pin_lvl[2]),
    .scl_f     (pin_lvl[0]),
    .sda_f     (pin_lvl[1]),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .ctl0_o    (ctl0_o),
    .ctl1_o    (ctl1_o)
  );

endmodule

// File: tb/test_ctlstat_i2c_slave.sv
module test_ctlstat_i2c_slave;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_m, scl_m, sda_m;
  logic [7:0] stat_m;
  logic       sda_oe;
  logic [7:0] ctl0, ctl1;
  wire        sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int q = 5;
  bit glitch_en = 1'b0;
  logic [7:0] exp0, exp1;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlstat_i2c_slave i_ctlstat_i2c_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_m),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe),
    .stat_i   (stat_m),
    .ctl0_o   (ctl0),
    .ctl1_o   (ctl1)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_fail++;
      $display("FAIL R11 watchdog: cycles %0d expected below %0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [7:0] strap_ctl0(input logic scl, input logic sda);
    return {sda, 1'b0, 2'b01, (scl ? 2'b10 : 2'b01), 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(q);
    scl_m = 1'b1; wq(2*q);
    sda_m = 1'b0; wq(2*q);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wq(q); sda_m = 1'b0; wq(q);
    scl_m = 1'b1; wq(2*q);
    sda_m = 1'b1; wq(2*q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      wq(q); sda_m = b[i];
      if (glitch_en && i == 5) begin
        scl_m = 1'b1; wq(2); scl_m = 1'b0;
      end
      wq(q); scl_m = 1'b1; wq(q);
      if (glitch_en && i == 3) begin
        sda_m = ~b[i]; wq(2); sda_m = b[i];
      end
      wq(q); scl_m = 1'b0;
    end
    wq(q); sda_m = 1'b1; wq(q);
    scl_m = 1'b1; wq(q);
    ack = ~sda_line;
    wq(q); scl_m = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit m_ack);
    b = '0;
    for (int i = 7; i >= 0; i--) begin
      wq(q); sda_m = 1'b1; wq(q);
      scl_m = 1'b1; wq(q);
      b = {b[6:0], sda_line};
      wq(q); scl_m = 1'b0;
    end
    wq(q); sda_m = ~m_ack; wq(q);
    scl_m = 1'b1; wq(2*q); scl_m = 1'b0;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] b0, input logic [7:0] b1,
                          output bit ka, output bit k0, output bit k1);
    bus_start();
    send_byte({a, 1'b0}, ka);
    k0 = 1'b0; k1 = 1'b0;
    if (ka) begin
      send_byte(b0, k0);
      send_byte(b1, k1);
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] st_a, input logic [7:0] st_b,
                         output bit ka, output logic [7:0] d);
    stat_m = st_a;
    bus_start();
    send_byte({7'h1C, 1'b1}, ka);
    stat_m = st_b;
    d = '0;
    if (ka) recv_byte(d, 1'b0);
    bus_stop();
  endtask

  initial begin
    bit ka, k0, k1, k2;
    logic [7:0] d, b0, b1, st_a, st_b;
    logic [6:0] bad;
    int seed_val;
    seed_val = $urandom(32'd7411);
    rst_n = 1'b0; mode_m = 1'b1; scl_m = 1'b1; sda_m = 1'b1; stat_m = 8'h00;
    wq(5); rst_n = 1'b1; wq(10);

    chk("R6 ctl0 after reset", ctl0, 8'h14);
    chk("R6 ctl1 after reset", ctl1, 8'h00);
    chk("R6 sda_oe after reset", {7'd0, sda_oe}, 8'h00);
    exp0 = 8'h14; exp1 = 8'h00;

    // directed write
    q = 10;
    do_write(7'h1C, 8'hA5, 8'h3C, ka, k0, k1);
    chk("R1 address ack", {7'd0, ka}, 8'h01);
    chk("R2 byte0 ack", {7'd0, k0}, 8'h01);
    chk("R2 byte1 ack", {7'd0, k1}, 8'h01);
    exp0 = 8'hA5; exp1 = 8'h3C;
    chk("R2 ctl0 written", ctl0, exp0);
    chk("R2 ctl1 written", ctl1, exp1);

    // wrong address
    do_write(7'h1D, 8'h00, 8'hFF, ka, k0, k1);
    chk("R1 foreign address nack", {7'd0, ka}, 8'h00);
    chk("R1 ctl0 untouched", ctl0, exp0);

    // three data bytes
    bus_start();
    send_byte(8'h38, ka);
    send_byte(8'h5A, k0);
    send_byte(8'hC3, k1);
    send_byte(8'h99, k2);
    bus_stop();
    exp0 = 8'h5A; exp1 = 8'hC3;
    chk("R3 third byte nack", {7'd0, k2}, 8'h00);
    chk("R3 ctl0 from first byte", ctl0, exp0);
    chk("R3 ctl1 from second byte", ctl1, exp1);

    // read with status change after address ack
    do_read(8'hB2, 8'h4D, ka, d);
    chk("R4 read address ack", {7'd0, ka}, 8'h01);
    chk("R4 snapshot data", d, 8'hB2);
    do_read(8'h6E, 8'h6E, ka, d);
    chk("R5 read after nack", d, 8'h6E);
    chk("R5 sda released", {7'd0, sda_oe}, 8'h00);

    // glitches on SCL and SDA
    glitch_en = 1'b1;
    do_write(7'h1C, 8'hFF, 8'h08, ka, k0, k1);
    glitch_en = 1'b0;
    exp0 = 8'hFF; exp1 = 8'h08;
    chk("R9 glitched byte ack", {7'd0, k0}, 8'h01);
    chk("R9 ctl0 after glitches", ctl0, exp0);
    chk("R9 ctl1 after glitches", ctl1, exp1);

    // repeated start between write byte and read
    bus_start();
    send_byte(8'h38, ka);
    send_byte(8'h21, k0);
    stat_m = 8'h93;
    bus_start();
    send_byte(8'h39, ka);
    recv_byte(d, 1'b0);
    bus_stop();
    exp0 = 8'h21;
    chk("R10 repeated start read", d, 8'h93);
    chk("R10 ctl0 kept first byte", ctl0, exp0);

    // STOP in the middle of a byte
    bus_start();
    send_byte(8'h38, ka);
    for (int i = 0; i < 4; i++) begin
      wq(q); sda_m = 1'b0; wq(q); scl_m = 1'b1; wq(2*q); scl_m = 1'b0;
    end
    bus_stop();
    chk("R10 aborted byte not written", ctl0, exp0);

    // strap mode
    mode_m = 1'b0;
    for (int k = 0; k < 4; k++) begin
      scl_m = k[0]; sda_m = k[1];
      wq(12);
      chk("R7 strap ctl0", ctl0, strap_ctl0(k[0], k[1]));
      chk("R7 strap ctl1", ctl1, 8'h00);
    end
    scl_m = 1'b1; sda_m = 1'b1; wq(12);
    do_write(7'h1C, 8'h11, 8'h22, ka, k0, k1);
    chk("R7 no ack in strap mode", {7'd0, ka}, 8'h00);
    mode_m = 1'b1; wq(12);
    chk("R8 ctl0 restored", ctl0, exp0);
    chk("R8 ctl1 restored", ctl1, exp1);

    // random traffic at several bus speeds
    for (int it = 0; it < 36; it++) begin
      int op;
      int sel;
      sel = $urandom_range(0, 2);
      q = (sel == 0) ? 5 : ((sel == 1) ? 10 : 20);
      op = $urandom_range(0, 2);
      if (op == 0) begin
        b0 = 8'($urandom); b1 = 8'($urandom);
        do_write(7'h1C, b0, b1, ka, k0, k1);
        exp0 = b0; exp1 = b1;
        chk("R11 random write ack", {6'd0, k0, k1}, 8'h03);
        chk("R11 random ctl0", ctl0, exp0);
        chk("R11 random ctl1", ctl1, exp1);
      end else if (op == 1) begin
        st_a = 8'($urandom); st_b = 8'($urandom);
        do_read(st_a, st_b, ka, d);
        chk("R4 random read", d, st_a);
      end else begin
        bad = 7'($urandom);
        if (bad == 7'h1C) bad = 7'h1E;
        do_write(bad, 8'($urandom), 8'($urandom), ka, k0, k1);
        chk("R1 random foreign nack", {7'd0, ka}, 8'h00);
        chk("R1 random foreign no write", ctl0, exp0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule